// File: doc/BRIEF.md
# Seconds-Based Watchdog Timer

This block is a watchdog peripheral that counts down in whole seconds. Software reaches it through an 8-byte register window: a control/status word and a timeout word. A prescaler divides the input clock by `CLK_HZ` to make a one-second tick. While the watchdog is running, each tick takes one second off the remaining time. Software keeps the system alive by writing a one-shot reload bit more often than the programmed timeout. If the remaining time runs out, the block raises either a system-reset request or a power-off request, whichever software selected. The request lasts `PULSE_CYCLES` clocks.

There are two reset inputs. Power-on reset clears everything. System reset is synchronous and clears everything except a sticky flag that records that the watchdog expired. Software can therefore tell, after the restart, that the watchdog caused it. A global enable input can switch the whole timer function off, and the control word reports that state.

Top module: `sec_wdog`

## Requirements
- R1: After power-on reset, with the enable input high, the control word reads 0, the timeout word reads `DEFAULT_SECS`, and both request outputs are low.
- R2: Address bit 2 selects the word; address bits 1:0 are ignored. Control word at offset 0: bit 0 RUN (1 counting), bit 1 EXPIRED flag, bit 2 ACTION (0 reset request, 1 power-off request), bit 3 OFF (reads 1 while the enable input is low), bit 7 RELOAD (always reads 0), all other bits read 0. Timeout word at offset 4: bits 9:0 hold the timeout in seconds, all other bits read 0.
- R3: A control write that sets RUN and RELOAD together, sampled at clock edge E, reloads the timeout N and restarts the prescaler. With no further writes, the selected request output rises exactly at edge E + N*`CLK_HZ`.
- R4: A RELOAD write while running restarts the full timeout, including a full first second. A control write with RELOAD at 0 and RUN at 1 does not change when expiry happens.
- R5: A control write that clears RUN freezes both the remaining seconds and the prescaler. Setting RUN again without RELOAD resumes from the frozen point. If the remaining time is zero (for example after an expiry), setting RUN loads the full timeout.
- R6: On expiry, the reset request (ACTION 0) or the power-off request (ACTION 1) stays high for exactly `PULSE_CYCLES` cycles. The two outputs are never high together.
- R7: Expiry clears RUN.
- R8: Expiry sets EXPIRED. Only power-on reset, or a control write with bit 1 at 1, clears it. System reset and writes with bit 1 at 0 leave it unchanged.
- R9: While the enable input is low, OFF reads 1, RUN is held at 0, RELOAD writes are ignored, and no expiry occurs. This holds even if the enable input drops mid-countdown.
- R10: A write to the timeout word whose bits 9:0 are all zero is ignored. Bits above 9 are discarded.
- R11: A low system reset, sampled at a clock edge, returns RUN, ACTION, the timeout word, the countdown and the request outputs to their reset values.
- R12: If the last second ends in the same cycle as a RELOAD write, the reload wins and no expiry occurs. If it ends in the same cycle as a write that clears RUN, the stop wins and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears all state |
| sys_rst_n | input | 1 | Synchronous system reset, active low; keeps the EXPIRED flag |
| wd_enable | input | 1 | Global enable of the timer function |
| reg_addr | input | 3 | Byte offset within the register window |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| sys_reset_req | output | 1 | Reset request pulse on expiry |
| power_off_req | output | 1 | Power-off request pulse on expiry |

## Verification
A prescaler or countdown that is off by one shows up as a request edge one clock early or late, or a whole `CLK_HZ` period off. The bench therefore samples both outputs at the exact edge before and the edge of the expected rise and fall. If the frozen state after a stop is lost, the resume-time check catches it within one timeout. A wrong EXPIRED or RUN value becomes visible in the next control-word read. The bench takes that read right after each expiry, system reset and power-on reset.

// File: rtl/sec_wdog_pkg.sv
package sec_wdog_pkg;

    // control word bit positions (software decodes these)
    localparam int CTRL_RUN_BIT   = 0;
    localparam int CTRL_FIRED_BIT = 1;
    localparam int CTRL_ACT_BIT   = 2;
    localparam int CTRL_OFF_BIT   = 3;
    localparam int CTRL_TRIG_BIT  = 7;

    // byte-address bit that selects control (0) or timeout (1) word
    localparam int WIN_SEL_BIT    = 2;

    typedef enum logic {
        ACT_RESET    = 1'b0,
        ACT_POWEROFF = 1'b1
    } expiry_act_e;

endpackage

// File: rtl/sec_wdog_regs.sv
module sec_wdog_regs
    import sec_wdog_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 3,
    parameter int SECS_W       = 10,
    parameter int DEFAULT_SECS = 60
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              expire,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              running,
    output expiry_act_e       action,
    output logic              trig,
    output logic              start,
    output logic              halt,
    output logic [SECS_W-1:0] reload
);

    localparam logic [SECS_W-1:0] RELOAD_RST = SECS_W'(DEFAULT_SECS);

    typedef struct packed {
        logic              running;
        logic              fired;
        expiry_act_e       action;
        logic [SECS_W-1:0] reload;
    } regs_t;

    regs_t regs_d, regs_q;

    logic ctrl_wr;
    logic cnt_wr;
    logic stop_wr;
    logic unused_bits;

    assign unused_bits = ^{reg_addr, reg_wdata};

    always_comb begin
        ctrl_wr = reg_wr && !reg_addr[WIN_SEL_BIT];
        cnt_wr  = reg_wr &&  reg_addr[WIN_SEL_BIT];
        stop_wr = ctrl_wr && !reg_wdata[CTRL_RUN_BIT] && regs_q.running;
        trig    = ctrl_wr && reg_wdata[CTRL_TRIG_BIT] && enable && sys_rst_n;
        start   = ctrl_wr && reg_wdata[CTRL_RUN_BIT] && !reg_wdata[CTRL_TRIG_BIT]
                  && !regs_q.running && enable && sys_rst_n;
        halt    = stop_wr || !enable;

        regs_d = regs_q;
        if (ctrl_wr) begin
            regs_d.running = reg_wdata[CTRL_RUN_BIT] && enable;
            regs_d.action  = expiry_act_e'(reg_wdata[CTRL_ACT_BIT]);
            if (reg_wdata[CTRL_FIRED_BIT]) begin
                regs_d.fired = 1'b0;
            end
        end
        if (cnt_wr && (reg_wdata[SECS_W-1:0] != '0)) begin
            regs_d.reload = reg_wdata[SECS_W-1:0];
        end
        if (expire) begin
            regs_d.running = 1'b0;
            regs_d.fired   = 1'b1;
        end
        if (!enable) begin
            regs_d.running = 1'b0;
        end
        if (!sys_rst_n) begin
            regs_d.running = 1'b0;
            regs_d.action  = ACT_RESET;
            regs_d.reload  = RELOAD_RST;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            regs_q <= '{running: 1'b0, fired: 1'b0, action: ACT_RESET, reload: RELOAD_RST};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_addr[WIN_SEL_BIT]) begin
            reg_rdata[CTRL_RUN_BIT]   = regs_q.running;
            reg_rdata[CTRL_FIRED_BIT] = regs_q.fired;
            reg_rdata[CTRL_ACT_BIT]   = regs_q.action;
            reg_rdata[CTRL_OFF_BIT]   = !enable;
        end else begin
            reg_rdata[SECS_W-1:0]     = regs_q.reload;
        end
    end

    assign running = regs_q.running;
    assign action  = regs_q.action;
    assign reload  = regs_q.reload;

    AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (!por_n)
        expire |=> !regs_q.running); // R7

    AST_EXPIRE_FLAGS: assert property (@(posedge clk) disable iff (!por_n)
        expire |=> regs_q.fired); // R8

    AST_FLAG_SURVIVES: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n && !expire && !reg_wr) |=> $stable(regs_q.fired)); // R8

    AST_OFF_NO_RUN: assert property (@(posedge clk) disable iff (!por_n)
        !enable |=> !regs_q.running); // R9

    AST_ZERO_SECS_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
        (cnt_wr && sys_rst_n && (reg_wdata[SECS_W-1:0] == '0)) |=> $stable(regs_q.reload)); // R10

endmodule

// File: rtl/sec_wdog_prescale.sv
module sec_wdog_prescale #(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst_n,
    input  logic run,
    input  logic halt,
    input  logic restart,
    output logic tick
);

    localparam int             CNT_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_HZ - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } presc_t;

    presc_t presc_d, presc_q;

    always_comb begin
        presc_d = presc_q;
        if (restart) begin
            presc_d.cnt = '0;
        end else if (run && !halt) begin
            presc_d.cnt = (presc_q.cnt == LAST) ? '0 : presc_q.cnt + 1'b1;
        end
        if (!sys_rst_n) begin
            presc_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            presc_q <= '0;
        end else begin
            presc_q <= presc_d;
        end
    end

    assign tick = run && (presc_q.cnt == LAST);

    AST_FULL_FIRST_SECOND: assert property (@(posedge clk) disable iff (!por_n)
        restart |=> (CLK_HZ == 1) || !tick); // R4

endmodule

// File: rtl/sec_wdog_countdown.sv
module sec_wdog_countdown #(
    parameter int SECS_W = 10
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              running,
    input  logic              trig,
    input  logic              start,
    input  logic              halt,
    input  logic              tick,
    input  logic [SECS_W-1:0] reload,
    output logic              load,
    output logic              expire
);

    typedef struct packed {
        logic [SECS_W-1:0] remain;
    } cd_t;

    cd_t cd_d, cd_q;
    logic step;

    always_comb begin
        load   = trig || (start && (cd_q.remain == '0));
        step   = tick && running && !halt && !trig;
        expire = step && (cd_q.remain == SECS_W'(1)) && sys_rst_n;

        cd_d = cd_q;
        if (load) begin
            cd_d.remain = reload;
        end else if (step && (cd_q.remain != '0)) begin
            cd_d.remain = cd_q.remain - 1'b1;
        end
        if (!sys_rst_n) begin
            cd_d.remain = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cd_q <= '0;
        end else begin
            cd_q <= cd_d;
        end
    end

    AST_RELOAD_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (!por_n)
        (trig && sys_rst_n) |=> (cd_q.remain != '0)); // R12

endmodule

// File: rtl/sec_wdog_pulse.sv
module sec_wdog_pulse
    import sec_wdog_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        sys_rst_n,
    input  logic        expire,
    input  expiry_act_e action,
    output logic        rst_req,
    output logic        off_req
);

    localparam int PW = $clog2(PULSE_CYCLES + 1);
    localparam logic [PW-1:0] LEN = PW'(PULSE_CYCLES);

    typedef struct packed {
        logic [PW-1:0] left;
        expiry_act_e   act;
    } pulse_t;

    pulse_t pulse_d, pulse_q;

    always_comb begin
        pulse_d = pulse_q;
        if (expire) begin
            pulse_d.left = LEN;
            pulse_d.act  = action;
        end else if (pulse_q.left != '0) begin
            pulse_d.left = pulse_q.left - 1'b1;
        end
        if (!sys_rst_n) begin
            pulse_d.left = '0;
            pulse_d.act  = ACT_RESET;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pulse_q <= '{left: '0, act: ACT_RESET};
        end else begin
            pulse_q <= pulse_d;
        end
    end

    assign rst_req = (pulse_q.left != '0) && (pulse_q.act == ACT_RESET);
    assign off_req = (pulse_q.left != '0) && (pulse_q.act == ACT_POWEROFF);

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({rst_req, off_req})); // R6

    AST_REQ_ON_EXPIRY: assert property (@(posedge clk) disable iff (!por_n)
        (expire && sys_rst_n) |=> (rst_req || off_req)); // R6

endmodule

// File: rtl/sec_wdog.sv
module sec_wdog
    import sec_wdog_pkg::*;
#(
    parameter int CLK_HZ       = 100_000_000,
    parameter int DATA_W       = 32,
    parameter int SECS_W       = 10,
    parameter int DEFAULT_SECS = 60,
    parameter int PULSE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              wd_enable,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sys_reset_req,
    output logic              power_off_req
);

    localparam int ADDR_W = 3;

    logic              running;
    expiry_act_e       action;
    logic              trig;
    logic              start;
    logic              halt;
    logic [SECS_W-1:0] reload;
    logic              load;
    logic              expire;
    logic              tick;

    sec_wdog_regs #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .SECS_W      (SECS_W),
        .DEFAULT_SECS(DEFAULT_SECS)
    ) u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .enable    (wd_enable),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .expire    (expire),
        .reg_rdata (reg_rdata),
        .running   (running),
        .action    (action),
        .trig      (trig),
        .start     (start),
        .halt      (halt),
        .reload    (reload)
    );

    sec_wdog_prescale #(
        .CLK_HZ(CLK_HZ)
    ) u_prescale (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .run       (running),
        .halt      (halt),
        .restart   (load),
        .tick      (tick)
    );

    sec_wdog_countdown #(
        .SECS_W(SECS_W)
    ) u_countdown (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .running   (running),
        .trig      (trig),
        .start     (start),
        .halt      (halt),
        .tick      (tick),
        .reload    (reload),
        .load      (load),
        .expire    (expire)
    );

    sec_wdog_pulse #(
        .PULSE_CYCLES(PULSE_CYCLES)
    ) u_pulse (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .expire    (expire),
        .action    (action),
        .rst_req   (sys_reset_req),
        .off_req   (power_off_req)
    );

endmodule

// File: tb/sec_wdog_bench.sv
module sec_wdog_bench;

    localparam int H   = 8;
    localparam int P   = 4;
    localparam int DEF = 60;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        wd_enable = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sys_reset_req;
    logic        power_off_req;

    int unsigned cyc = 0;
    int unsigned last_edge = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sec_wdog #(
        .CLK_HZ      (H),
        .DATA_W      (32),
        .SECS_W      (10),
        .DEFAULT_SECS(DEF),
        .PULSE_CYCLES(P)
    ) u_sec_wdog (
        .clk          (clk),
        .por_n        (por_n),
        .sys_rst_n    (sys_rst_n),
        .wd_enable    (wd_enable),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .sys_reset_req(sys_reset_req),
        .power_off_req(power_off_req)
    );

    function automatic logic [31:0] ctrl_val(input bit run, input bit fired, input bit act, input bit off);
        return {28'd0, off, act, fired, run};
    endfunction

    function automatic logic [31:0] req_val(input bit active, input bit act);
        return {30'd0, active && act, active && !act};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_edge(input int unsigned t);
        while (cyc < t) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        #2;
        reg_wr    = 1'b0;
        last_edge = cyc;
    endtask

    task automatic wr_at(input int unsigned t, input logic [2:0] a, input logic [31:0] d);
        wait_edge(t - 1);
        wr(a, d);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic sys_reset();
        @(negedge clk);
        sys_rst_n = 1'b0;
        @(posedge clk);
        #2;
        sys_rst_n = 1'b1;
    endtask

    function automatic logic [31:0] outs();
        return {30'd0, power_off_req, sys_reset_req};
    endfunction

    task automatic expect_expiry(input string tag, input int unsigned t, input bit act);
        wait_edge(t - 1);
        chk({tag, " before"}, outs(), req_val(1'b0, act));
        wait_edge(t);
        chk({tag, " rise"}, outs(), req_val(1'b1, act));
        wait_edge(t + P - 1);
        chk({tag, " hold"}, outs(), req_val(1'b1, act));
        wait_edge(t + P);
        chk({tag, " fall"}, outs(), req_val(1'b0, act));
    endtask

    task automatic expect_quiet(input string tag, input int unsigned t0, input int unsigned t1);
        logic [31:0] bad;
        bad = '0;
        for (int unsigned t = t0; t <= t1; t++) begin
            wait_edge(t);
            if (outs() != '0 && bad == '0) bad = outs();
        end
        chk(tag, bad, 32'd0);
    endtask

    initial begin
        logic [31:0] v;
        int unsigned e0, s, r, t;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        por_n = 1'b1;
        sys_rst_n = 1'b1;
        @(posedge clk);
        #2;

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 32'd0);
        rd(3'd4, v); chk("R1 secs", v, DEF);
        chk("R1 outputs", outs(), 32'd0);

        // R2 window decode, RELOAD reads zero
        rd(3'd7, v); chk("R2 addr7", v, DEF);
        rd(3'd3, v); chk("R2 addr3", v, 32'd0);
        wr(3'd4, 32'd5);
        wr(3'd0, 32'h85);
        rd(3'd1, v); chk("R2 trig reads 0", v, ctrl_val(1, 0, 1, 0));
        wr(3'd0, 32'h0);

        // R10 zero write ignored, upper bits dropped
        wr(3'd4, 32'h407);
        rd(3'd4, v); chk("R10 upper bits", v, 32'd7);
        wr(3'd4, 32'h400);
        rd(3'd4, v); chk("R10 zero ignored", v, 32'd7);
        wr(3'd4, 32'd0);
        rd(3'd4, v); chk("R10 zero ignored 2", v, 32'd7);

        // R3 basic timing, R7 run clears
        wr(3'd4, 32'd2);
        wr(3'd0, 32'h81);
        e0 = last_edge;
        expect_expiry("R3", e0 + 2 * H, 1'b0);
        rd(3'd0, v); chk("R7 after expiry", v, ctrl_val(0, 1, 0, 0));

        // R8 flag: write 0 keeps, system reset keeps, write 1 clears
        wr(3'd0, 32'h0);
        rd(3'd0, v); chk("R8 write0 keeps", v, ctrl_val(0, 1, 0, 0));
        wr(3'd4, 32'd9);
        sys_reset();
        rd(3'd0, v); chk("R8 survives sysrst", v, ctrl_val(0, 1, 0, 0));
        rd(3'd4, v); chk("R11 secs default", v, DEF);
        wr(3'd0, 32'h2);
        rd(3'd0, v); chk("R8 w1c", v, 32'd0);

        // R8 power-on reset clears flag
        wr(3'd4, 32'd1);
        wr(3'd0, 32'h81);
        expect_expiry("R8 setup", last_edge + H, 1'b0);
        @(negedge clk); por_n = 1'b0; #3; por_n = 1'b1;
        rd(3'd0, v); chk("R8 por clears", v, 32'd0);

        // R4 RELOAD at 0 has no effect on timing
        wr(3'd4, 32'd2);
        wr(3'd0, 32'h81);
        e0 = last_edge;
        wr_at(e0 + 5, 3'd0, 32'h01);
        expect_expiry("R4 no-trig write", e0 + 2 * H, 1'b0);
        wr(3'd0, 32'h2);

        // R4 reload mid-count restarts full time
        wr(3'd0, 32'h81);
        e0 = last_edge;
        wr_at(e0 + 10, 3'd0, 32'h81);
        t = last_edge;
        expect_quiet("R4 no early expiry", e0 + 1, t + 2 * H - 1);
        expect_expiry("R4 reload", t + 2 * H, 1'b0);
        wr(3'd0, 32'h2);

        // R5 stop freezes, resume continues
        wr(3'd4, 32'd3);
        wr(3'd0, 32'h85);
        e0 = last_edge;
        wr_at(e0 + 10, 3'd0, 32'h04);
        s = last_edge;
        expect_quiet("R5 frozen", s, s + 40);
        wr(3'd0, 32'h05);
        r = last_edge;
        expect_expiry("R5 resume", r + 3 * H - (s - e0 - 1), 1'b1);

        // R5 resume after expiry loads full time
        wr(3'd0, 32'h05);
        r = last_edge;
        expect_expiry("R5 reload on resume", r + 3 * H, 1'b1);
        wr(3'd0, 32'h2);

        // R12 reload at final tick
        wr(3'd4, 32'd1);
        wr(3'd0, 32'h81);
        e0 = last_edge;
        wr_at(e0 + H, 3'd0, 32'h81);
        t = last_edge;
        expect_quiet("R12 reload wins", t, t + H - 1);
        expect_expiry("R12 after reload", t + H, 1'b0);
        wr(3'd0, 32'h2);

        // R12 stop at final tick
        wr(3'd0, 32'h81);
        e0 = last_edge;
        wr_at(e0 + H, 3'd0, 32'h00);
        expect_quiet("R12 stop wins", e0 + H, e0 + H + 20);
        rd(3'd0, v); chk("R12 no flag", v, 32'd0);

        // R9 enable low
        wd_enable = 1'b0;
        rd(3'd0, v); chk("R9 off bit", v, ctrl_val(0, 0, 0, 1));
        wr(3'd0, 32'h81);
        rd(3'd0, v); chk("R9 run blocked", v, ctrl_val(0, 0, 0, 1));
        expect_quiet("R9 no expiry", last_edge, last_edge + 3 * H);
        wd_enable = 1'b1;
        wr(3'd0, 32'h81);
        e0 = last_edge;
        wait_edge(e0 + 3);
        @(negedge clk); wd_enable = 1'b0;
        expect_quiet("R9 drop mid-count", e0 + 4, e0 + 3 * H);
        wd_enable = 1'b1;
        rd(3'd0, v); chk("R9 run cleared", v, 32'd0);

        // R11 system reset cuts a request
        wr(3'd0, 32'h85);
        t = last_edge + H;
        wait_edge(t + 1);
        chk("R11 request up", outs(), req_val(1'b1, 1'b1));
        sys_reset();
        chk("R11 request dropped", outs(), 32'd0);
        rd(3'd0, v); chk("R11 ctrl", v, ctrl_val(0, 1, 0, 0));
        wr(3'd0, 32'h2);

        // R6 random runs
        for (int i = 0; i < 20; i++) begin
            int unsigned n;
            bit          act;
            n   = 1 + ($urandom % 4);
            act = bit'($urandom % 2);
            wr(3'd4, n);
            wr(3'd0, {24'd0, 8'h81} | (32'(act) << 2));
            expect_expiry("R6 random", last_edge + n * H, act);
            rd(3'd0, v); chk("R7 random ctrl", v, ctrl_val(0, 1, act, 0));
            wr(3'd0, 32'h2 | (32'(act) << 2));
            rd(3'd0, v); chk("R8 random clear", v, ctrl_val(0, 0, act, 0));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule